// File: doc/BRIEF.md
# Four-State (1+D)^2 Sequence Detector

This block recovers hard bit decisions from an equalised sample stream whose target response is (1+D)^2, one signed sample per bit. Each accepted sample is scored against the ideal noiseless values of the eight trellis branches. A four-state add-compare-select array then keeps the best path into every state. A register-exchange survivor store of DEPTH bits per state gives one decision per sample from the currently best state, so the latency in samples is constant. The ideal levels follow from the target and the level step parameter, so the block holds no channel estimation and no adaptation. When a tie occurs in add-compare-select, the lower-numbered predecessor state wins.

Both sides use valid/ready streams. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high. The output holds at most one decision. `in_ready` is high when that slot is empty or is being drained in the same cycle, so back-pressure on the output stops intake straight away and no sample is lost. An optional postcoder undoes a transmit-side precoder of the form c_k = b_k xor c_{k-2}. It is selected by a plain pin that is changed only during reset.

Top module: `pr2_viterbi`

## Requirements
- R1: A sample is consumed only on a clock edge where in_valid and in_ready are both high, and in_ready equals (not out_valid) or out_ready in every cycle.
- R2: After reset, out_valid first rises in the cycle after the DEPTH-th consumed sample. From then on, each consumed sample yields exactly one decision, and the decisions leave in input order, so output number j belongs to input bit number j.
- R3: Path metrics are renormalised after every consumed sample so that the smallest is zero and none reaches 2^(BMW+1). Decoding stays exact over streams of any length.
- R4: While out_valid is high and out_ready is low, out_valid stays high and out_bit keeps its value.
- R5: With postcode_en=1, the output bits equal the user bits b_k. These are related to the channel bits by c_k = b_k xor c_{k-2}, with c_{-1}=c_{-2}=0. Decoding is error-free for additive noise of magnitude at most STEP/4 on each sample.
- R6: With postcode_en=0, the output bits are the detected channel bits c_k themselves.
- R7: Channel bit 1 maps to +1 and bit 0 maps to -1. The noiseless sample is STEP*(a_k + 2a_{k-1} + a_{k-2}), which takes one of the five levels -4, -2, 0, +2 or +4 times STEP. A noiseless stream decodes exactly at full rate.
- R8: A synchronous reset clears the path metrics, the fill count and the postcoder history, and it forces out_valid low. After reset, R2's latency applies again from the first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| postcode_en | input | 1 | 1: emit postcoded user bits, 0: emit channel bits |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | W | Signed equalised sample |
| out_valid | output | 1 | Decision held in the output slot |
| out_ready | input | 1 | Downstream takes the decision |
| out_bit | output | 1 | Hard decision |

## Verification
A corrupted path metric or a wrong add-compare-select choice shows up as a wrong decision at out_bit. It appears up to DEPTH consumed samples later, once the faulty survivor becomes the best path. A fill counter that is off by one shifts the first rise of out_valid by a cycle, and the per-clock comparison against the behavioural model catches this in the cycle it happens. A wrong postcoder history bit corrupts the next one or two decisions. Dropped or duplicated samples under back-pressure leave every later decision out of step with the delayed reference.

// File: rtl/pr2_viterbi_pkg.sv
package pr2_viterbi_pkg;
  localparam int NSTATE  = 4;
  localparam int NBRANCH = 8;

  // branch index {new bit, bit k-1, bit k-2}; bit 1 -> +1, bit 0 -> -1
  function automatic int ideal_level(input logic [2:0] br, input int step);
    int s;
    s = (br[2] ? 1 : -1) + (br[1] ? 2 : -2) + (br[0] ? 1 : -1);
    return s * step;
  endfunction
endpackage

// File: rtl/pr2_bmu.sv
module pr2_bmu #(
  parameter int W    = 8,
  parameter int STEP = 16,
  parameter int BMW  = 20
) (
  input  logic signed [W-1:0]                                in_sample,
  output logic [pr2_viterbi_pkg::NBRANCH-1:0][BMW-1:0]       bm
);
  localparam int DW = BMW / 2;

  generate
    for (genvar i = 0; i < pr2_viterbi_pkg::NBRANCH; i++) begin : g_br
      localparam int LVL = pr2_viterbi_pkg::ideal_level(3'(i), STEP);
      logic signed [DW-1:0] diff;
      assign diff  = DW'(in_sample) - DW'(LVL);
      assign bm[i] = BMW'(diff * diff);
    end
  endgenerate
endmodule

// File: rtl/pr2_acs.sv
module pr2_acs #(
  parameter int BMW = 20,
  parameter int MW  = 22
) (
  input  logic                                               clk,
  input  logic                                               rst,
  input  logic                                               en,
  input  logic [pr2_viterbi_pkg::NBRANCH-1:0][BMW-1:0]       bm,
  output logic [pr2_viterbi_pkg::NSTATE-1:0][MW-1:0]         pm_q,
  output logic [pr2_viterbi_pkg::NSTATE-1:0]                 dec,
  output logic [1:0]                                         best
);
  localparam int NS = pr2_viterbi_pkg::NSTATE;

  logic [NS-1:0][MW-1:0] nxt, norm;
  logic [MW-1:0]         mn;

  // state index {bit k-1, bit k-2}; state d is entered from {d[0],0} or {d[0],1}
  generate
    for (genvar d = 0; d < NS; d++) begin : g_st
      localparam int P0 = (d % 2) * 2;
      logic [MW-1:0] c0, c1;
      assign c0     = pm_q[P0]   + MW'(bm[2*d]);
      assign c1     = pm_q[P0+1] + MW'(bm[2*d+1]);
      assign dec[d] = (c1 < c0);
      assign nxt[d] = dec[d] ? c1 : c0;
    end
  endgenerate

  always_comb begin
    mn   = nxt[0];
    best = 2'd0;
    for (int s = 1; s < NS; s++) begin
      if (nxt[s] < mn) begin
        mn   = nxt[s];
        best = 2'(s);
      end
    end
    for (int s = 0; s < NS; s++) norm[s] = nxt[s] - mn;
  end

  always_ff @(posedge clk) begin
    if (rst)     pm_q <= '0;
    else if (en) pm_q <= norm;
  end
endmodule

// File: rtl/pr2_survivor.sv
module pr2_survivor #(
  parameter int DEPTH = 20
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                en,
  input  logic [pr2_viterbi_pkg::NSTATE-1:0]  dec,
  input  logic [1:0]                          best,
  output logic                                bit_out
);
  localparam int NS = pr2_viterbi_pkg::NSTATE;

  logic [NS-1:0][DEPTH-1:0] path, nxt;

  generate
    for (genvar d = 0; d < NS; d++) begin : g_st
      localparam int  PH = (d % 2) * 2;
      localparam logic X = (d >= 2) ? 1'b1 : 1'b0;
      assign nxt[d] = {(dec[d] ? path[PH+1][DEPTH-2:0] : path[PH][DEPTH-2:0]), X};
    end
  endgenerate

  assign bit_out = nxt[best][DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst)     path <= '0;
    else if (en) path <= nxt;
  end
endmodule

// File: rtl/pr2_viterbi.sv
module pr2_viterbi #(
  parameter int W     = 8,
  parameter int STEP  = 16,
  parameter int DEPTH = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                postcode_en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_bit
);
  localparam int BMW = 2 * (W + 2);
  localparam int MW  = BMW + 2;
  localparam int FW  = $clog2(DEPTH);
  localparam int NS  = pr2_viterbi_pkg::NSTATE;
  localparam int NB  = pr2_viterbi_pkg::NBRANCH;

  logic                  fire, full, emit, chan_bit;
  logic [FW-1:0]         fill;
  logic [1:0]            hist;   // {c(j-2), c(j-1)} of emitted decisions
  logic [NB-1:0][BMW-1:0] bm;
  logic [NS-1:0][MW-1:0] pm_q;
  logic [NS-1:0]         dec;
  logic [1:0]            best;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign full     = (fill == FW'(DEPTH - 1));
  assign emit     = fire && full;

  pr2_bmu #(.W(W), .STEP(STEP), .BMW(BMW)) u_bmu (
    .in_sample (in_sample),
    .bm        (bm)
  );

  pr2_acs #(.BMW(BMW), .MW(MW)) u_acs (
    .clk  (clk),
    .rst  (rst),
    .en   (fire),
    .bm   (bm),
    .pm_q (pm_q),
    .dec  (dec),
    .best (best)
  );

  pr2_survivor #(.DEPTH(DEPTH)) u_surv (
    .clk     (clk),
    .rst     (rst),
    .en      (fire),
    .dec     (dec),
    .best    (best),
    .bit_out (chan_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      hist      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      if (fire && !full) fill <= fill + 1'b1;
      if (emit) begin
        out_valid <= 1'b1;
        out_bit   <= postcode_en ? (chan_bit ^ hist[1]) : chan_bit;
        hist      <= {hist[0], chan_bit};
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pr2_viterbi_chk.sv
module pr2_viterbi_chk #(
  parameter int BMW = 20,
  parameter int MW  = 22
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic                  out_bit,
  input logic                  fire,
  input logic [3:0][MW-1:0]    pm
);
  localparam logic [MW-1:0] LIM = MW'(1) << (BMW + 1);

  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (pm[0] < LIM) && (pm[1] < LIM) && (pm[2] < LIM) && (pm[3] < LIM));

  a_r3_min_zero: assert property (@(posedge clk) disable iff (rst)
    $past(fire) |-> ((pm[0] == '0) || (pm[1] == '0) || (pm[2] == '0) || (pm[3] == '0)));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind pr2_viterbi pr2_viterbi_chk #(.BMW(BMW), .MW(MW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .fire      (fire),
  .pm        (pm_q)
);

// File: tb/pr2_viterbi_tb_top.sv
module pr2_viterbi_tb_top;
  localparam int W = 8, STEP = 16, DEPTH = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, postcode_en = 1'b1, in_valid = 1'b0, out_ready = 1'b0;
  logic signed [W-1:0] in_sample = '0;
  logic in_ready, out_valid, out_bit;

  pr2_viterbi #(.W(W), .STEP(STEP), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .postcode_en(postcode_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_sample(in_sample),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  int total = 0, bad = 0;
  bit exp_q[$];
  int n_acc, n_out, noise_b, cur_sample;
  bit c1, c2, cur_b, cur_c, all_ones, raw;
  bit [6:0] lfsr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep();
    int lvl;
    cur_b = all_ones ? 1'b1 : lfsr[6];
    cur_c = cur_b ^ c2;
    lvl = STEP * ((cur_c ? 1 : -1) + (c1 ? 2 : -2) + (c2 ? 1 : -1));
    cur_sample = lvl + ((noise_b > 0) ? (int'($urandom_range(0, 2 * noise_b)) - noise_b) : 0);
  endtask

  task automatic do_reset(input bit pc);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; postcode_en = pc;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    n_acc = 0; n_out = 0; c1 = 0; c2 = 0; lfsr = 7'h7F;
    exp_q.delete();
    raw = !pc;
    prep();
  endtask

  task automatic run_phase(input string tag, input int n, input int pv, input int pr);
    bit prev_stall = 0, prev_bit = 0, mv, e;
    int target = n - DEPTH + 1;
    forever begin
      @(negedge clk);
      mv = (n_acc >= DEPTH) && (n_out < n_acc - DEPTH + 1);
      check(out_valid == mv, "R2 out_valid timing", out_valid, mv);
      if (prev_stall) check(out_valid && (out_bit == prev_bit), "R4 hold on stall", out_bit, prev_bit);
      if (n_out >= target) break;
      in_valid  = (n_acc < n) && (int'($urandom_range(0, 99)) < pv);
      out_ready = int'($urandom_range(0, 99)) < pr;
      in_sample = W'(cur_sample);
      #1;
      check(in_ready == (!out_valid || out_ready), "R1 in_ready rule", in_ready, !out_valid || out_ready);
      if (out_valid && out_ready) begin
        e = exp_q.pop_front();
        check(out_bit == e, tag, out_bit, e);
        n_out++;
      end
      prev_stall = out_valid && !out_ready;
      prev_bit   = out_bit;
      if (in_valid && in_ready) begin
        exp_q.push_back(raw ? cur_c : cur_b);
        c2 = c1; c1 = cur_c;
        lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
        n_acc++;
        prep();
      end
    end
    in_valid = 1'b0;
  endtask

  initial begin
    noise_b = STEP / 4; all_ones = 0;
    do_reset(1'b1);
    run_phase("R5 postcoded PRBS with noise", 400, 70, 60);
    noise_b = 0; all_ones = 1;
    do_reset(1'b1);
    run_phase("R7 noiseless levels full rate", 80, 100, 100);
    noise_b = STEP / 4; all_ones = 0;
    do_reset(1'b0);
    run_phase("R6 raw channel bits", 300, 80, 30);
    do_reset(1'b1);
    run_phase("R3 long stream metrics", 1500, 100, 100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule